// File: doc/BRIEF.md
# Valley-Skip Selection Counter

This block holds a small saturating count that tells a quasi-resonant switching controller how many ringing valleys to let pass before the power switch turns on again. A high count lengthens the off-time for light load. A low count shortens it for heavy load. The feedback level reaches the block as three digitised comparator flags: above the low threshold, above the high threshold, and above the reload threshold. A one-cycle evaluation strobe marks the end of each judging period.

Between strobes the block remembers the highest threshold the feedback reached. At the strobe it acts on that memory:
- It counts up if no threshold was reached.
- It holds if only the low threshold was reached.
- It counts down if the high threshold was reached.

The count stays within its limits, 1 to 7 by default. The up and down steps use different thresholds, which gives hysteresis and stops the count from chattering. When the feedback goes above the reload threshold, the count drops to 1 on the next clock edge. This lets the controller respond quickly to a sudden rise in load. That event also clears the memory, so the period is judged again from that point.

Top module: `vskip_sel_counter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `skip_count` reads 1 (unsigned binary).
- R2: When no threshold flag was high in any cycle of a period, including the strobe cycle, `skip_count` rises by one on the clock edge that samples `tick`=1.
- R3: A count-up step at 7 is ignored and the count stays at 7.
- R4: When `fb_above_lo` was high in at least one cycle of the period and `fb_above_hi` in none, the count is unchanged at the strobe.
- R5: When `fb_above_hi` was high in at least one cycle of the period, the count falls by one at the strobe.
- R6: A count-down step at 1 is ignored and the count stays at 1.
- R7: On any clock edge that samples `fb_above_rst`=1, the count becomes 1, whether or not `tick` is high.
- R8: The period memory is sticky. A flag that was high for a single cycle anywhere in the period, including the strobe cycle itself, counts for the decision. The high threshold takes precedence over the low one.
- R9: The memory is cleared at each strobe, so a crossing in one period has no effect on the decision at the end of the next period.
- R10: The memory is also cleared when a reload occurs. A high-threshold crossing before the reload, in the same period, does not cause a count-down at the next strobe.
- R11: On clock edges where both `tick` and `fb_above_rst` are 0, `skip_count` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low start-up reset; loads the count with 1 |
| tick | input | 1 | One-cycle evaluation strobe that ends a period |
| fb_above_lo | input | 1 | 1 = feedback above the low (hold) threshold |
| fb_above_hi | input | 1 | 1 = feedback above the high (count-down) threshold |
| fb_above_rst | input | 1 | 1 = feedback above the reload threshold |
| skip_count | output | CNT_W | Number of valleys to skip, unsigned |

## Verification
The bench targets the following corner cases:
- **Saturation at both ends.** A design that wrapped would jump from 7 to 0 or from 1 to 0.
- **Single-cycle pulses early in a period.** A design without sticky memory, one that looked only at the strobe cycle, would count up where it should count down.
- **A crossing on the strobe cycle itself.** A design that registered the flags before deciding would lose this crossing.
- **A reload mid-period after a high-threshold pulse.** A design that kept its memory across the reload would step down from 1 instead of up.
- **A reload on the strobe cycle.** A wrong precedence would apply the step instead of the reload.

Every cycle is compared, so a count that moves outside a strobe or a reload is also caught.

// File: rtl/vskip_pkg.sv
`timescale 1ns/1ps
package vskip_pkg;
   typedef enum logic [1:0] {
      ACT_UP   = 2'd0,
      ACT_HOLD = 2'd1,
      ACT_DOWN = 2'd2,
      ACT_LOAD = 2'd3
   } vs_act_e;

   localparam int LVL_LO  = 0;
   localparam int LVL_HI  = 1;
   localparam int LVL_RST = 2;
   localparam int NUM_LVL = 3;
endpackage

// File: rtl/vskip_peak_mem.sv
`timescale 1ns/1ps
module vskip_peak_mem #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] lvl_in,
   output logic [N-1:0] seen
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         seen_q <= 1'b0;
         else if (clr)       seen_q <= 1'b0;
         else if (lvl_in[i]) seen_q <= 1'b1;
      end
      assign seen[i] = seen_q;

      // R8
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_in[i] && !clr) |=> seen[i]);
   end

   // R9
   mem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (seen == '0));
endmodule

// File: rtl/vskip_act_dec.sv
`timescale 1ns/1ps
module vskip_act_dec
   import vskip_pkg::*;
#(
   parameter bit FAST_RELOAD = 1'b1
) (
   input  logic               tick,
   input  logic [NUM_LVL-1:0] lvl_in,
   input  logic [NUM_LVL-1:0] seen,
   output vs_act_e            act,
   output logic               step_en
);
   logic [NUM_LVL-1:0] eff;
   logic               reload_now;

   assign eff = seen | lvl_in;

   if (FAST_RELOAD) begin : g_fast
      assign reload_now = lvl_in[LVL_RST];
   end else begin : g_slow
      assign reload_now = tick & eff[LVL_RST];
   end

   always_comb begin
      act     = ACT_HOLD;
      step_en = 1'b0;
      if (reload_now) begin
         act     = ACT_LOAD;
         step_en = 1'b1;
      end else if (tick) begin
         step_en = 1'b1;
         if (eff[LVL_HI])      act = ACT_DOWN;
         else if (eff[LVL_LO]) act = ACT_HOLD;
         else                  act = ACT_UP;
      end
   end
endmodule

// File: rtl/vskip_sat_cnt.sv
`timescale 1ns/1ps
module vskip_sat_cnt
   import vskip_pkg::*;
#(
   parameter int CNT_W    = 3,
   parameter int CNT_MIN  = 1,
   parameter int CNT_MAX  = 7,
   parameter int LOAD_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  vs_act_e          act,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(CNT_MIN);
   localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(LOAD_VAL);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= INIT_V;
      end else if (en) begin
         case (act)
            ACT_UP:   if (cnt_q < LIM_HI) cnt_q <= cnt_q + 1'b1;
            ACT_DOWN: if (cnt_q > LIM_LO) cnt_q <= cnt_q - 1'b1;
            ACT_LOAD: cnt_q <= INIT_V;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end
   assign cnt = cnt_q;

   // R2
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act == ACT_UP && cnt_q < LIM_HI) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act == ACT_DOWN && cnt_q > LIM_LO) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act == ACT_HOLD) |=> $stable(cnt_q));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= LIM_LO) && (cnt_q <= LIM_HI));
endmodule

// File: rtl/vskip_sel_counter.sv
`timescale 1ns/1ps
module vskip_sel_counter
   import vskip_pkg::*;
#(
   parameter int CNT_W       = 3,
   parameter int CNT_MIN     = 1,
   parameter int CNT_MAX     = 7,
   parameter int LOAD_VAL    = 1,
   parameter bit FAST_RELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             fb_above_lo,
   input  logic             fb_above_hi,
   input  logic             fb_above_rst,
   output logic [CNT_W-1:0] skip_count
);
   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(LOAD_VAL);

   initial begin : param_chk
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
      assert (CNT_MIN >= 0 && CNT_MIN < CNT_MAX) else $error("bad count limits");
      assert (CNT_MAX < (1 << CNT_W)) else $error("CNT_MAX exceeds CNT_W");
      assert (LOAD_VAL >= CNT_MIN && LOAD_VAL <= CNT_MAX) else $error("LOAD_VAL outside limits");
   end

   logic [NUM_LVL-1:0] lvl_in;
   logic [NUM_LVL-1:0] seen;
   vs_act_e            act;
   logic               step_en;

   assign lvl_in[LVL_LO]  = fb_above_lo;
   assign lvl_in[LVL_HI]  = fb_above_hi;
   assign lvl_in[LVL_RST] = fb_above_rst;

   vskip_peak_mem #(.N(NUM_LVL)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (step_en),
      .lvl_in (lvl_in),
      .seen   (seen)
   );

   vskip_act_dec #(.FAST_RELOAD(FAST_RELOAD)) u_dec (
      .tick    (tick),
      .lvl_in  (lvl_in),
      .seen    (seen),
      .act     (act),
      .step_en (step_en)
   );

   vskip_sat_cnt #(
      .CNT_W    (CNT_W),
      .CNT_MIN  (CNT_MIN),
      .CNT_MAX  (CNT_MAX),
      .LOAD_VAL (LOAD_VAL)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (step_en),
      .act   (act),
      .cnt   (skip_count)
   );

   if (FAST_RELOAD) begin : g_fast_chk
      // R7
      reload_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fb_above_rst |=> (skip_count == INIT_V));

      // R11
      quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !fb_above_rst) |=> $stable(skip_count));
   end
endmodule

// File: tb/vskip_sel_counter_test.sv
`timescale 1ns/1ps
module vskip_sel_counter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       fb_above_lo = 1'b0;
   logic       fb_above_hi = 1'b0;
   logic       fb_above_rst = 1'b0;
   logic [2:0] skip_count;

   always #2 clk = ~clk;

   vskip_sel_counter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .fb_above_lo  (fb_above_lo),
      .fb_above_hi  (fb_above_hi),
      .fb_above_rst (fb_above_rst),
      .skip_count   (skip_count)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   int    q_val[$];
   int    q_due[$];
   string q_tag[$];

   int mc = 1;
   bit flo = 1'b0;
   bit fhi = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input int act_v, input int exp_v, input string tag);
      n_cmp++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s: skip_count=%0d expected %0d", tag, act_v, exp_v);
      end
   endtask

   // monitor: pops scoreboard items that fall due on this cycle
   always @(negedge clk) begin
      if (rst_n) begin
         while (q_due.size() > 0 && q_due[0] <= cyc) begin
            check(int'(skip_count), q_val[0], q_tag[0]);
            void'(q_val.pop_front());
            void'(q_due.pop_front());
            void'(q_tag.pop_front());
         end
      end
   end

   // driver: one period, single-cycle pulses at given indices (-1 = none)
   task automatic run_period(input int len, input int lo_at, input int hi_at,
                             input int rs_at, input string note);
      for (int i = 0; i < len; i++) begin
         bit    lo, hi, rs, tk;
         string tag;
         @(negedge clk);
         lo = (i == lo_at);
         hi = (i == hi_at);
         rs = (i == rs_at);
         tk = (i == len - 1);
         fb_above_lo  = lo;
         fb_above_hi  = hi;
         fb_above_rst = rs;
         tick         = tk;
         if (rs) begin
            mc = 1; flo = 1'b0; fhi = 1'b0;
            tag = "R7 reload";
         end else if (tk) begin
            if (fhi || hi) begin
               tag = (mc == 1) ? "R6 down-sat" : "R5 down";
               if (mc > 1) mc = mc - 1;
            end else if (flo || lo) begin
               tag = "R4 hold";
            end else begin
               tag = (mc == 7) ? "R3 up-sat" : "R2 up";
               if (mc < 7) mc = mc + 1;
            end
            flo = 1'b0; fhi = 1'b0;
         end else begin
            flo = flo | lo;
            fhi = fhi | hi;
            tag = "R11 idle";
         end
         q_val.push_back(mc);
         q_due.push_back(cyc + 1);
         q_tag.push_back({tag, " ", note});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(int'(skip_count), 1, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(int'(skip_count), 1, "R1 after reset");

      for (int k = 0; k < 8; k++) run_period(3, -1, -1, -1, "quiet");
      run_period(4, 1, -1, -1, "lo pulse");
      run_period(5, -1, 0, -1, "R8 early hi pulse");
      run_period(5, 0, 2, -1, "R8 lo and hi");
      run_period(4, -1, 3, -1, "R8 hi on tick cycle");
      run_period(4, -1, -1, -1, "R9 after hi period");
      for (int k = 0; k < 5; k++) run_period(3, -1, 1, -1, "hi");
      for (int k = 0; k < 3; k++) run_period(3, -1, -1, -1, "quiet");
      run_period(6, -1, 0, 2, "R10 hi then reload");
      run_period(3, -1, -1, -1, "quiet");
      run_period(4, -1, 1, 3, "R7 reload on tick");
      run_period(3, -1, -1, -1, "quiet");
      run_period(3, -1, -1, 0, "R7 reload at start");
      run_period(4, 2, -1, -1, "lo near tick");

      @(negedge clk);
      fb_above_lo = 1'b0; fb_above_hi = 1'b0; fb_above_rst = 1'b0; tick = 1'b0;
      repeat (3) @(negedge clk);
      check(int'(skip_count), mc, "R11 final idle");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, R11 progress actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule